// File: doc/BRIEF.md
# Display Register Window Bridge

This block turns a memory-mapped slave window into the register traffic of a display controller. It decodes three subregions inside the window. The first is a remap of the legacy byte-wide display I/O ports that start at port 0x3C0. The second is a 16-bit indexed extension register file, reached through an index cycle followed by a data cycle. The third is an optional extended block that reports its own size and holds the framebuffer byte-order flag. A strap input decides whether the extended block is present, and the strap also selects the revision value the block reports.

The requester places an access on the slave port and holds it until the block raises `reqReady` for one cycle. The block then breaks the access into the byte-wide port cycles or index/data cycles it needs, issues them in a fixed order on its core-side interfaces, and assembles any read data into `rspRdata`. The core answers each cycle combinationally in the cycle it is issued. Window layout: the legacy ports sit at 0x400 (0x20 bytes), the indexed file at 0x500 (0x18 bytes), and the extended block at 0x600 (8 bytes).

Top module: `mmio_win_bridge`

## Requirements
- R1: A 1-byte access at legacy offset N (window address 0x400+N) issues exactly one port cycle at port 0x3C0+N, and the access completes with `reqReady` two cycles after acceptance.
- R2: A legacy write of S bytes (S from 1 to 4) issues S port cycles on consecutive cycles at ports 0x3C0+N, 0x3C1+N, ... in ascending order, with byte i taken from `reqWdata[8i+7:8i]`, so the lowest (index) byte reaches the core first.
- R3: A legacy read of S bytes returns the data of port 0x3C0+N+i in `rspRdata[8i+7:8i]` and zero in the unread upper bytes.
- R4: Any access at indexed offset M (window address 0x500+M) issues an index write (`xregSel`=0, `xregWrite`=1, data M>>1) and on the next cycle a single 16-bit data cycle (`xregSel`=1) carrying `reqWdata[15:0]` on a write; a read returns the 16-bit data in `rspRdata[15:0]` with bits 31:16 zero.
- R5: In the extended block only 4-byte accesses decode: offset 0 reads 8 (the block size), offset 4 reads the byte-order code (0x1E1E1E1E little endian, 0xBEBEBEBE big endian), and every other offset reads zero. An access of another size there behaves as unmapped.
- R6: The byte-order flag resets to little endian (`bigEndian`=0). A 4-byte write at extended offset 4 sets it only for 0xBEBEBEBE and clears it only for 0x1E1E1E1E; any other value leaves it unchanged.
- R7: With `extStrap`=0 the extended block is absent: its addresses read zero, writes there leave the byte order unchanged, and `revisionId` is 1; with `extStrap`=1 `revisionId` is 2.
- R8: An access outside every enabled subregion issues no port or indexed cycle, returns zero, and completes on the cycle after acceptance.
- R9: `reqReady` is a single-cycle pulse that closes each access; legacy accesses complete S+1 cycles after acceptance, indexed accesses 3 cycles after, extended accesses 2 cycles after, and no core cycle is issued unless a request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| extStrap | input | 1 | Enables the extended block and revision 2 |
| reqValid | input | 1 | Access pending; held with its fields until reqReady |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 12 | Byte offset inside the window |
| reqSize | input | 3 | Access size in bytes (1, 2, 3 or 4) |
| reqWdata | input | 32 | Write data, little-endian byte lanes |
| reqReady | output | 1 | One-cycle completion pulse |
| rspRdata | output | 32 | Read data, valid while reqReady is high |
| portValid | output | 1 | Legacy port cycle this clock |
| portWrite | output | 1 | Legacy port cycle is a write |
| portAddr | output | 16 | Legacy port number |
| portWdata | output | 8 | Legacy port write byte |
| portRdata | input | 8 | Legacy port read byte from the core, same cycle |
| xregValid | output | 1 | Indexed-file cycle this clock |
| xregSel | output | 1 | 0 = index register, 1 = data register |
| xregWrite | output | 1 | Indexed-file cycle is a write |
| xregWdata | output | 16 | Index value or data written |
| xregRdata | input | 16 | Data read from the indexed file, same cycle |
| bigEndian | output | 1 | Current framebuffer byte order, 1 = big endian |
| revisionId | output | 8 | Revision value reported for the strap setting |

## Verification
The checker watches every cycle for the ordering properties: port cycles of one access climb by one port at a time, a data cycle to the indexed file is always preceded by its index write, the two core interfaces are never active together, no core cycle appears without a pending request, the completion pulse lasts a single cycle, and the byte-order flag moves only while the strap is set. What those properties cannot show is the content: the exact port numbers and bytes, the assembled read words, the register values of the extended block, the rejection of non-code writes, the strap's effect on decoding and the exact completion latency. Those come from the bench's reference model, which predicts every core cycle of each scenario and compares it on each clock.

// File: rtl/mmio_win_pkg.sv
package mmio_win_pkg;

  localparam int DATA_W = 32;
  localparam int BYTES  = DATA_W / 8;
  localparam int LANE_W = $clog2(BYTES);

  localparam logic [DATA_W-1:0] ORDER_LITTLE = 32'h1E1E_1E1E;
  localparam logic [DATA_W-1:0] ORDER_BIG    = 32'hBEBE_BEBE;

  typedef enum logic [1:0] {
    RGN_NONE,
    RGN_LEG,
    RGN_IDX,
    RGN_EXT
  } region_e;

  // Strobes from the control FSM to the datapath.
  typedef struct packed {
    logic              start;   // access accepted, latch request
    logic              legGo;   // legacy byte cycle on lane
    logic [LANE_W-1:0] lane;
    logic              xIdxGo;  // indexed-file index write
    logic              xDatGo;  // indexed-file data cycle
    logic              extGo;   // extended block access
    logic              done;    // completion pulse
  } strobe_t;

endpackage

// File: rtl/mmio_win_decode.sv
module mmio_win_decode
  import mmio_win_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int LEG_BASE = 'h400,
  parameter int LEG_SIZE = 'h20,
  parameter int IDX_BASE = 'h500,
  parameter int IDX_SIZE = 'h18,
  parameter int EXT_BASE = 'h600,
  parameter int EXT_SIZE = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [2:0]        size,
  input  logic              extEnable,
  output region_e           region,
  output logic [ADDR_W-1:0] offset
);

  localparam logic [ADDR_W-1:0] LEG_LO = ADDR_W'(LEG_BASE);
  localparam logic [ADDR_W-1:0] LEG_HI = ADDR_W'(LEG_BASE + LEG_SIZE);
  localparam logic [ADDR_W-1:0] IDX_LO = ADDR_W'(IDX_BASE);
  localparam logic [ADDR_W-1:0] IDX_HI = ADDR_W'(IDX_BASE + IDX_SIZE);
  localparam logic [ADDR_W-1:0] EXT_LO = ADDR_W'(EXT_BASE);
  localparam logic [ADDR_W-1:0] EXT_HI = ADDR_W'(EXT_BASE + EXT_SIZE);
  localparam logic [2:0]        MAX_SZ = 3'(BYTES);

  logic legHit, idxHit, extHit, sizeOk;

  assign sizeOk = (size != 3'd0) && (size <= MAX_SZ);
  assign legHit = sizeOk && (addr >= LEG_LO) && (addr < LEG_HI);
  assign idxHit = sizeOk && (addr >= IDX_LO) && (addr < IDX_HI);
  assign extHit = extEnable && (size == MAX_SZ) && (addr >= EXT_LO) && (addr < EXT_HI);

  always_comb begin
    region = RGN_NONE;
    offset = '0;
    if (legHit) begin
      region = RGN_LEG;
      offset = addr - LEG_LO;
    end else if (idxHit) begin
      region = RGN_IDX;
      offset = addr - IDX_LO;
    end else if (extHit) begin
      region = RGN_EXT;
      offset = addr - EXT_LO;
    end
  end

endmodule

// File: rtl/mmio_win_ctrl.sv
module mmio_win_ctrl
  import mmio_win_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  region_e region,
  input  logic [2:0] reqSize,
  output strobe_t stb
);

  typedef enum logic [2:0] {
    S_IDLE,
    S_LEG,
    S_XIDX,
    S_XDAT,
    S_EXT,
    S_DONE
  } state_e;

  state_e state, nextState;
  logic [LANE_W-1:0] laneCnt;
  logic [LANE_W-1:0] lastLane;

  always_comb begin
    stb       = '0;
    nextState = state;
    stb.lane  = laneCnt;
    unique case (state)
      S_IDLE: begin
        if (reqValid) begin
          stb.start = 1'b1;
          unique case (region)
            RGN_LEG: nextState = S_LEG;
            RGN_IDX: nextState = S_XIDX;
            RGN_EXT: nextState = S_EXT;
            default: nextState = S_DONE;
          endcase
        end
      end
      S_LEG: begin
        stb.legGo = 1'b1;
        if (laneCnt == lastLane) nextState = S_DONE;
      end
      S_XIDX: begin
        stb.xIdxGo = 1'b1;
        nextState  = S_XDAT;
      end
      S_XDAT: begin
        stb.xDatGo = 1'b1;
        nextState  = S_DONE;
      end
      S_EXT: begin
        stb.extGo = 1'b1;
        nextState = S_DONE;
      end
      S_DONE: begin
        stb.done  = 1'b1;
        nextState = S_IDLE;
      end
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_IDLE;
      laneCnt  <= '0;
      lastLane <= '0;
    end else begin
      state <= nextState;
      if (stb.start) begin
        laneCnt  <= '0;
        lastLane <= LANE_W'(reqSize - 3'd1);
      end else if (stb.legGo) begin
        laneCnt <= laneCnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/mmio_win_datapath.sv
module mmio_win_datapath
  import mmio_win_pkg::*;
#(
  parameter int          ADDR_W    = 12,
  parameter logic [15:0] PORT_BASE = 16'h03C0,
  parameter int          EXT_SIZE  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] offset,
  input  logic [DATA_W-1:0] reqWdata,
  output logic [DATA_W-1:0] rspRdata,
  output logic              portValid,
  output logic              portWrite,
  output logic [15:0]       portAddr,
  output logic [7:0]        portWdata,
  input  logic [7:0]        portRdata,
  output logic              xregValid,
  output logic              xregSel,
  output logic              xregWrite,
  output logic [15:0]       xregWdata,
  input  logic [15:0]       xregRdata,
  output logic              bigEndian
);

  localparam logic [ADDR_W-1:0] OFS_SIZE  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFS_ORDER = ADDR_W'(4);

  logic              writeQ;
  logic [ADDR_W-1:0] offsetQ;
  logic [DATA_W-1:0] wdataQ;
  logic [DATA_W-1:0] extVal;
  logic [7:0]        wrByte [BYTES];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      writeQ  <= 1'b0;
      offsetQ <= '0;
      wdataQ  <= '0;
    end else if (stb.start) begin
      writeQ  <= reqWrite;
      offsetQ <= offset;
      wdataQ  <= reqWdata;
    end
  end

  // Extended block read value.
  always_comb begin
    extVal = '0;
    if (offsetQ == OFS_SIZE)       extVal = DATA_W'(EXT_SIZE);
    else if (offsetQ == OFS_ORDER) extVal = bigEndian ? ORDER_BIG : ORDER_LITTLE;
  end

  // Byte-order flag: only exact codes move it.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      bigEndian <= 1'b0;
    end else if (stb.extGo && writeQ && offsetQ == OFS_ORDER) begin
      if (wdataQ == ORDER_BIG)         bigEndian <= 1'b1;
      else if (wdataQ == ORDER_LITTLE) bigEndian <= 1'b0;
    end
  end

  // Read assembly, one register per byte lane.
  for (genvar b = 0; b < BYTES; b++) begin : g_lane
    logic [7:0] laneQ;
    assign wrByte[b] = wdataQ[8*b +: 8];
    always_ff @(posedge clk) begin
      if (!rstN || stb.start) begin
        laneQ <= '0;
      end else if (!writeQ) begin
        if (stb.legGo && stb.lane == LANE_W'(b)) begin
          laneQ <= portRdata;
        end else if (stb.extGo) begin
          laneQ <= extVal[8*b +: 8];
        end else if (stb.xDatGo) begin
          laneQ <= (b < 2) ? xregRdata[8*(b%2) +: 8] : 8'h00;
        end
      end
    end
    assign rspRdata[8*b +: 8] = laneQ;
  end

  // Legacy port cycles.
  assign portValid = stb.legGo;
  assign portWrite = stb.legGo && writeQ;
  assign portAddr  = PORT_BASE + 16'(offsetQ) + 16'(stb.lane);
  assign portWdata = wrByte[stb.lane];

  // Indexed-file cycles: index write first, then data.
  assign xregValid = stb.xIdxGo || stb.xDatGo;
  assign xregSel   = stb.xDatGo;
  assign xregWrite = stb.xIdxGo || (stb.xDatGo && writeQ);
  assign xregWdata = stb.xIdxGo ? 16'(offsetQ >> 1) : wdataQ[15:0];

endmodule

// File: rtl/mmio_win_bridge.sv
module mmio_win_bridge
  import mmio_win_pkg::*;
#(
  parameter int          ADDR_W    = 12,
  parameter logic [15:0] PORT_BASE = 16'h03C0,
  parameter int          LEG_BASE  = 'h400,
  parameter int          LEG_SIZE  = 'h20,
  parameter int          IDX_BASE  = 'h500,
  parameter int          IDX_SIZE  = 'h18,
  parameter int          EXT_BASE  = 'h600,
  parameter int          EXT_SIZE  = 8,
  parameter logic [7:0]  BASE_REV  = 8'd1,
  parameter logic [7:0]  STRAP_REV = 8'd2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              extStrap,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [2:0]        reqSize,
  input  logic [31:0]       reqWdata,
  output logic              reqReady,
  output logic [31:0]       rspRdata,
  output logic              portValid,
  output logic              portWrite,
  output logic [15:0]       portAddr,
  output logic [7:0]        portWdata,
  input  logic [7:0]        portRdata,
  output logic              xregValid,
  output logic              xregSel,
  output logic              xregWrite,
  output logic [15:0]       xregWdata,
  input  logic [15:0]       xregRdata,
  output logic              bigEndian,
  output logic [7:0]        revisionId
);

  region_e           region;
  logic [ADDR_W-1:0] offset;
  strobe_t           stb;

  mmio_win_decode #(
    .ADDR_W(ADDR_W), .LEG_BASE(LEG_BASE), .LEG_SIZE(LEG_SIZE),
    .IDX_BASE(IDX_BASE), .IDX_SIZE(IDX_SIZE),
    .EXT_BASE(EXT_BASE), .EXT_SIZE(EXT_SIZE)
  ) u_decode (
    .addr(reqAddr), .size(reqSize), .extEnable(extStrap),
    .region(region), .offset(offset)
  );

  mmio_win_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid),
    .region(region), .reqSize(reqSize), .stb(stb)
  );

  mmio_win_datapath #(
    .ADDR_W(ADDR_W), .PORT_BASE(PORT_BASE), .EXT_SIZE(EXT_SIZE)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .reqWrite(reqWrite),
    .offset(offset), .reqWdata(reqWdata), .rspRdata(rspRdata),
    .portValid(portValid), .portWrite(portWrite), .portAddr(portAddr),
    .portWdata(portWdata), .portRdata(portRdata),
    .xregValid(xregValid), .xregSel(xregSel), .xregWrite(xregWrite),
    .xregWdata(xregWdata), .xregRdata(xregRdata), .bigEndian(bigEndian)
  );

  assign reqReady   = stb.done;
  assign revisionId = extStrap ? STRAP_REV : BASE_REV;

endmodule

// File: rtl/mmio_win_checker.sv
module mmio_win_checker #(
  parameter logic [15:0] PORT_BASE = 16'h03C0,
  parameter int          LEG_SIZE  = 'h20
) (
  input logic        clk,
  input logic        rstN,
  input logic        extStrap,
  input logic        reqValid,
  input logic        reqReady,
  input logic        portValid,
  input logic [15:0] portAddr,
  input logic        xregValid,
  input logic        xregSel,
  input logic        bigEndian
);

  localparam logic [15:0] PORT_TOP = PORT_BASE + 16'(LEG_SIZE) + 16'd3;

  a_r9_ready_pulse: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |=> !reqReady);

  a_r9_cycles_need_req: assert property (@(posedge clk) disable iff (!rstN)
    (portValid || xregValid) |-> reqValid);

  a_r8_one_target: assert property (@(posedge clk) disable iff (!rstN)
    !(portValid && xregValid));

  a_r4_index_first: assert property (@(posedge clk) disable iff (!rstN)
    (xregValid && xregSel) |-> $past(xregValid && !xregSel));

  a_r2_ascending: assert property (@(posedge clk) disable iff (!rstN)
    (portValid && $past(portValid)) |-> (portAddr == $past(portAddr) + 16'd1));

  a_r1_port_range: assert property (@(posedge clk) disable iff (!rstN)
    portValid |-> (portAddr >= PORT_BASE && portAddr < PORT_TOP));

  a_r7_order_needs_strap: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(bigEndian) |-> $past(extStrap));

endmodule

bind mmio_win_bridge mmio_win_checker #(
  .PORT_BASE(PORT_BASE), .LEG_SIZE(LEG_SIZE)
) u_chk (
  .clk(clk), .rstN(rstN), .extStrap(extStrap), .reqValid(reqValid),
  .reqReady(reqReady), .portValid(portValid), .portAddr(portAddr),
  .xregValid(xregValid), .xregSel(xregSel), .bigEndian(bigEndian)
);

// File: tb/mmio_win_bridge_tb.sv
module mmio_win_bridge_tb;

  localparam logic [31:0] LE_CODE = 32'h1E1E_1E1E;
  localparam logic [31:0] BE_CODE = 32'hBEBE_BEBE;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        extStrap = 1'b1;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [11:0] reqAddr = '0;
  logic [2:0]  reqSize = 3'd1;
  logic [31:0] reqWdata = '0;
  logic        reqReady;
  logic [31:0] rspRdata;
  logic        portValid, portWrite;
  logic [15:0] portAddr;
  logic [7:0]  portWdata, portRdata;
  logic        xregValid, xregSel, xregWrite;
  logic [15:0] xregWdata, xregRdata;
  logic        bigEndian;
  logic [7:0]  revisionId;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  mmio_win_bridge u_dut (
    .clk(clk), .rstN(rstN), .extStrap(extStrap), .reqValid(reqValid),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqSize(reqSize),
    .reqWdata(reqWdata), .reqReady(reqReady), .rspRdata(rspRdata),
    .portValid(portValid), .portWrite(portWrite), .portAddr(portAddr),
    .portWdata(portWdata), .portRdata(portRdata),
    .xregValid(xregValid), .xregSel(xregSel), .xregWrite(xregWrite),
    .xregWdata(xregWdata), .xregRdata(xregRdata),
    .bigEndian(bigEndian), .revisionId(revisionId)
  );

  // Behavioural core models.
  logic [7:0]  portMem [64];
  logic [15:0] xMem [32];
  logic [4:0]  xIdx = '0;
  initial begin
    for (int i = 0; i < 64; i++) portMem[i] = 8'h00;
    for (int i = 0; i < 32; i++) xMem[i] = 16'h0000;
  end
  assign portRdata = portMem[portAddr[5:0]];
  assign xregRdata = xMem[xIdx];
  always @(posedge clk) begin
    if (portValid && portWrite) portMem[portAddr[5:0]] <= portWdata;
    if (xregValid && xregWrite) begin
      if (!xregSel) xIdx <= xregWdata[4:0];
      else          xMem[xIdx] <= xregWdata;
    end
  end

  // Reference model state.
  logic [7:0]  shPort [64];
  logic [15:0] shX [32];
  logic        shBig = 1'b0;
  logic [24:0] expPortQ [$];  // {write, addr, data}
  logic [17:0] expXQ [$];     // {sel, write, data}
  initial begin
    for (int i = 0; i < 64; i++) shPort[i] = 8'h00;
    for (int i = 0; i < 32; i++) shX[i] = 16'h0000;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Per-cycle comparison of core-side traffic against the predicted queues.
  always @(negedge clk) begin
    if (rstN) begin
      if (portValid) begin
        if (expPortQ.size() == 0) begin
          chk(1'b0, "R8 unexpected port cycle", {16'h0, portAddr}, 32'h0);
        end else begin
          logic [24:0] e;
          e = expPortQ.pop_front();
          chk(portAddr == e[23:8] && portWrite == e[24] &&
              (!e[24] || portWdata == e[7:0]),
              "R2 port cycle", {7'h0, portWrite, portAddr, portWdata}, {7'h0, e});
        end
      end
      if (xregValid) begin
        if (expXQ.size() == 0) begin
          chk(1'b0, "R8 unexpected indexed cycle", {16'h0, xregWdata}, 32'h0);
        end else begin
          logic [17:0] e;
          e = expXQ.pop_front();
          chk(xregSel == e[17] && xregWrite == e[16] &&
              (!e[16] || xregWdata == e[15:0]),
              "R4 indexed cycle", {14'h0, xregSel, xregWrite, xregWdata}, {14'h0, e});
        end
      end
    end
  end

  task automatic access(input bit wr, input logic [11:0] a, input logic [2:0] sz,
                        input logic [31:0] wd, input int expLat,
                        input logic [31:0] expRd, input string req);
    int  lat = 0;
    bit  got = 0;
    logic [31:0] rd = '0;
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqSize = sz; reqWdata = wd;
    while (!got && lat < 20) begin
      @(negedge clk);
      lat++;
      if (reqReady) begin got = 1; rd = rspRdata; end
    end
    reqValid = 1'b0;
    chk(got && lat == expLat, {req, " latency"}, lat, expLat);
    if (!wr) chk(rd == expRd, {req, " read data"}, rd, expRd);
    chk(expPortQ.size() == 0 && expXQ.size() == 0, {req, " cycles issued"},
        expPortQ.size() + expXQ.size(), 0);
  endtask

  task automatic legacy(input bit wr, input logic [11:0] ofs, input logic [2:0] sz,
                        input logic [31:0] wd, input string req);
    logic [31:0] exp = '0;
    for (int i = 0; i < sz; i++) begin
      logic [5:0] p;
      p = 6'(ofs + 12'(i));
      expPortQ.push_back({wr, 16'h03C0 + 16'(ofs) + 16'(i), wd[8*i +: 8]});
      if (wr) shPort[p] = wd[8*i +: 8];
      else    exp[8*i +: 8] = shPort[p];
    end
    access(wr, 12'h400 + ofs, sz, wd, sz + 1, exp, req);
  endtask

  task automatic indexed(input bit wr, input logic [11:0] ofs, input logic [15:0] wd,
                         input string req);
    logic [4:0] ix;
    ix = 5'(ofs >> 1);
    expXQ.push_back({1'b0, 1'b1, 16'(ofs >> 1)});
    expXQ.push_back({1'b1, wr, wd});
    if (wr) shX[ix] = wd;
    access(wr, 12'h500 + ofs, 3'd2, {16'h0, wd}, 3, {16'h0, wr ? 16'h0 : shX[ix]}, req);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // Reset state (R6, R7, R9).
    chk(!reqReady && !portValid && !xregValid, "R9 reset idle", reqReady, 0);
    chk(bigEndian == 1'b0, "R6 reset little endian", bigEndian, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(revisionId == 8'd2, "R7 revision with strap", revisionId, 2);

    // R1: single byte write and read back.
    legacy(1, 12'h05, 3'd1, 32'hA5, "R1 byte write");
    legacy(0, 12'h05, 3'd1, 0, "R1 byte read");
    // R2: word write, index byte first.
    legacy(1, 12'h04, 3'd2, 32'h1234, "R2 word write");
    legacy(1, 12'h10, 3'd4, 32'hDEADBEEF, "R2 dword write");
    legacy(1, 12'h1C, 3'd3, 32'h00C0FFEE, "R2 three byte write");
    // R3: assembled reads.
    legacy(0, 12'h04, 3'd2, 0, "R3 word read");
    legacy(0, 12'h10, 3'd4, 0, "R3 dword read");
    legacy(0, 12'h1D, 3'd2, 0, "R3 word read upper zero");

    // R4: indexed file.
    indexed(1, 12'h06, 16'hCAFE, "R4 indexed write");
    indexed(1, 12'h00, 16'h1357, "R4 indexed write index 0");
    indexed(0, 12'h06, 16'h0, "R4 indexed read");
    indexed(0, 12'h16, 16'h0, "R4 indexed read last");

    // R5: extended block reads.
    access(0, 12'h600, 3'd4, 0, 2, 32'd8, "R5 size register");
    access(0, 12'h604, 3'd4, 0, 2, LE_CODE, "R5 order register");
    access(0, 12'h602, 3'd4, 0, 2, 32'h0, "R5 other offset");
    access(0, 12'h600, 3'd2, 0, 1, 32'h0, "R5 wrong size");

    // R6: byte order updates.
    access(1, 12'h604, 3'd4, BE_CODE, 2, 0, "R6 set big");
    chk(bigEndian == 1'b1, "R6 flag big", bigEndian, 1);
    access(0, 12'h604, 3'd4, 0, 2, BE_CODE, "R6 read big");
    access(1, 12'h604, 3'd4, 32'h12345678, 2, 0, "R6 bad code");
    access(0, 12'h604, 3'd4, 0, 2, BE_CODE, "R6 bad code ignored");
    access(1, 12'h600, 3'd4, LE_CODE, 2, 0, "R6 code at size offset");
    chk(bigEndian == 1'b1, "R6 size offset ignored", bigEndian, 1);
    access(1, 12'h604, 3'd4, LE_CODE, 2, 0, "R6 set little");
    chk(bigEndian == 1'b0, "R6 flag little", bigEndian, 0);

    // R7: strap off.
    @(negedge clk);
    extStrap = 1'b0;
    @(negedge clk);
    chk(revisionId == 8'd1, "R7 revision without strap", revisionId, 1);
    access(0, 12'h600, 3'd4, 0, 1, 32'h0, "R7 size hidden");
    access(1, 12'h604, 3'd4, BE_CODE, 1, 0, "R7 write hidden");
    chk(bigEndian == 1'b0, "R7 order unchanged", bigEndian, 0);
    @(negedge clk);
    extStrap = 1'b1;
    access(0, 12'h604, 3'd4, 0, 2, LE_CODE, "R7 order after strap");

    // R8: unmapped accesses.
    access(0, 12'h100, 3'd4, 0, 1, 32'h0, "R8 unmapped read");
    access(1, 12'h7F0, 3'd2, 32'hFFFF, 1, 0, "R8 unmapped write");
    access(0, 12'h420, 3'd1, 0, 1, 32'h0, "R8 past legacy end");
    legacy(0, 12'h1C, 3'd4, 0, "R8 legacy intact");

    // R9: back-to-back accesses with one idle cycle.
    legacy(1, 12'h00, 3'd1, 32'h3C, "R9 back to back a");
    legacy(0, 12'h00, 3'd1, 0, "R9 back to back b");

    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule